// File: doc/BRIEF.md
# Programmable External Bus Cycle Timer

This block paces each bus access in whole bus-clock cycles. A requester presents a space index, a region type and a direction. While the block is idle it accepts the request, runs the access for the right number of cycles, and then returns to idle. Internal memory and special-function-register accesses take a fixed short count. External accesses take the count held in a per-space wait-control byte.

An external access first spends a number of setup cycles with both strobes high. The active-low read or write strobe is then held low for a number of cycles. A trailing recovery cycle can follow, with the strobe high again. A busy flag covers the whole access. A one-cycle done pulse marks its last cycle.

Four control bytes, one per external space, are written and read through a small byte port. Undefined timing codes fall back to the reset timing and set a sticky error flag.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset every control byte reads 0x03, busy, done and code_err are 0, and rd_n and wr_n are 1.
- R2: An internal-memory access (region 0) lasts one cycle when slow_mem is 0 and two cycles when slow_mem is 1, with no strobe asserted.
- R3: A special-function-register access (region 1) lasts two cycles whatever slow_mem is, with no strobe asserted.
- R4: An external access (region 2 or 3) uses timing code bits [4:0] of the selected space. It gives setup = bits[4:3]+1 cycles with the strobe high, then strobe = bits[2:0] cycles with the strobe low. The legal codes are 00001-00110, 01010-01101 and 10011-10110.
- R5: When bit 6 of the selected space's byte is 1, an external access gains one final recovery cycle with the strobe high. When bit 6 is 0, no cycle is added.
- R6: busy is 1 in every cycle of an access and 0 in the cycle after it ends. done is 1 only in the last cycle, including the recovery cycle when there is one.
- R7: A request is taken only when busy is 0. A request raised while busy is high has no effect on the running access.
- R8: Bits 5 and 7 of each control byte always read 0, and writing them has no effect on timing or readback.
- R9: An illegal code is timed as 1 setup + 3 strobe cycles. Writing one sets code_err in the next cycle, and code_err stays set until reset.
- R10: rd_n goes low only during the strobe phase of an external read, and wr_n only during that of an external write. The two strobes are never low together.
- R11: The four control bytes are independent, at byte addresses 0 to 3 selected by cfg_addr, and a write to one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write enable |
| cfg_addr | input | 2 | Control byte select, read and write |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Selected control byte, bits 5 and 7 zero |
| slow_mem | input | 1 | Adds a wait cycle to internal memory accesses |
| req | input | 1 | Access request, taken when busy is 0 |
| req_space | input | 2 | External space index for the access |
| req_region | input | 2 | 0 internal memory, 1 special register, 2 or 3 external |
| req_write | input | 1 | 1 write, 0 read |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |
| code_err | output | 1 | Sticky flag for an illegal timing code written |

## Verification
A request sampled at a rising edge makes cycle 1 of the access start at that edge. busy, done and the strobes then hold their values for cycle k from the k-th edge after acceptance, and the cycle after the last one shows busy low. The bench drives at falling edges and samples every output at the falling edge inside each cycle. It compares the outputs cycle by cycle against setup, strobe and recovery counts that it works out from the code it wrote. Readback and code_err come from single registers, so the bench checks them one falling edge after the write edge.

// File: rtl/bct_pkg.sv
package bct_pkg;

    localparam int CNT_W = 3;
    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_DEFAULT = 5'b00011;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    typedef enum logic [1:0] {
        RGN_IMEM    = 2'd0,
        RGN_SFR     = 2'd1,
        RGN_EXT     = 2'd2,
        RGN_EXT_ALT = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV
    } state_e;

    typedef struct packed {
        logic             ext;
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] low;
        logic             recov;
    } timing_t;

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        case (c)
            5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101, 5'b00110,
            5'b01010, 5'b01011, 5'b01100, 5'b01101,
            5'b10011, 5'b10100, 5'b10101, 5'b10110: return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bct_wait_bank.sv
module bct_wait_bank
    import bct_pkg::*;
#(
    parameter int NUM_SPACES = 4,
    localparam int SPC_W = $clog2(NUM_SPACES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SPC_W-1:0]  addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [SPC_W-1:0]  sel_space,
    output logic [CODE_W-1:0] sel_code,
    output logic              sel_recov,
    output logic              err
);

    logic [CODE_W-1:0] code_q  [NUM_SPACES];
    logic              recov_q [NUM_SPACES];

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[g]  <= CODE_DEFAULT;
                recov_q[g] <= 1'b0;
            end else if (we && addr == SPC_W'(g)) begin
                code_q[g]  <= wdata[CODE_W-1:0];
                recov_q[g] <= wdata[6];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (we && !code_legal(wdata[CODE_W-1:0])) begin
            err <= 1'b1;
        end
    end

    always_comb begin
        rdata = {1'b0, recov_q[addr], 1'b0, code_q[addr]};
    end

    assign sel_code  = code_q[sel_space];
    assign sel_recov = recov_q[sel_space];

endmodule

// File: rtl/bct_decode.sv
module bct_decode
    import bct_pkg::*;
(
    input  region_e           region,
    input  logic              slow_mem,
    input  logic [CODE_W-1:0] code,
    input  logic              recov,
    output timing_t           timing
);

    logic [CODE_W-1:0] eff_code;

    always_comb begin
        eff_code = code_legal(code) ? code : CODE_DEFAULT;
        timing   = '0;
        case (region)
            RGN_IMEM: begin
                timing.lead = slow_mem ? CNT_W'(2) : CNT_W'(1);
            end
            RGN_SFR: begin
                timing.lead = CNT_W'(2);
            end
            default: begin
                timing.ext   = 1'b1;
                timing.lead  = CNT_W'(eff_code[4:3]) + CNT_ONE;
                timing.low   = CNT_W'(eff_code[2:0]);
                timing.recov = recov;
            end
        endcase
    end

endmodule

// File: rtl/bct_sequencer.sv
module bct_sequencer
    import bct_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  logic    req_write,
    input  timing_t timing,
    output logic    rd_n,
    output logic    wr_n,
    output logic    busy,
    output logic    done
);

    state_e           state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_q;
    logic             rec_q;
    logic             wr_q;
    logic             last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            low_q <= '0;
            rec_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        wr_q  <= req_write;
                        rec_q <= timing.recov;
                        low_q <= timing.low;
                        cnt   <= timing.lead - CNT_ONE;
                        state <= timing.ext ? ST_SETUP : ST_INT;
                    end
                end
                ST_INT: begin
                    if (last) state <= ST_IDLE;
                    else      cnt   <= cnt - CNT_ONE;
                end
                ST_SETUP: begin
                    if (last) begin
                        state <= ST_STROBE;
                        cnt   <= low_q - CNT_ONE;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                ST_STROBE: begin
                    if (last) state <= rec_q ? ST_RECOV : ST_IDLE;
                    else      cnt   <= cnt - CNT_ONE;
                end
                ST_RECOV: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = ((state == ST_INT) && last) ||
               ((state == ST_STROBE) && last && !rec_q) ||
               (state == ST_RECOV);
        rd_n = !((state == ST_STROBE) && !wr_q);
        wr_n = !((state == ST_STROBE) && wr_q);
    end

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int NUM_SPACES = 4,
    localparam int SPC_W = $clog2(NUM_SPACES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SPC_W-1:0] cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             slow_mem,
    input  logic             req,
    input  logic [SPC_W-1:0] req_space,
    input  logic [1:0]       req_region,
    input  logic             req_write,
    output logic             rd_n,
    output logic             wr_n,
    output logic             busy,
    output logic             done,
    output logic             code_err
);

    logic [CODE_W-1:0] sel_code;
    logic              sel_recov;
    timing_t           timing;
    logic              take;

    bct_wait_bank #(.NUM_SPACES(NUM_SPACES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .sel_space (req_space),
        .sel_code  (sel_code),
        .sel_recov (sel_recov),
        .err       (code_err)
    );

    bct_decode u_decode (
        .region   (region_e'(req_region)),
        .slow_mem (slow_mem),
        .code     (sel_code),
        .recov    (sel_recov),
        .timing   (timing)
    );

    assign take = req && !busy;

    bct_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (take),
        .req_write (req_write),
        .timing    (timing),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/bct_checker.sv
module bct_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_rdata,
    input logic       rd_n,
    input logic       wr_n,
    input logic       busy,
    input logic       done,
    input logic       code_err
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (rd_n || wr_n)); // R10

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> busy); // R10

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R6

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7] == 1'b0 && cfg_rdata[5] == 1'b0)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err); // R9

endmodule

bind bus_cycle_timer bct_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .busy      (busy),
    .done      (done),
    .code_err  (code_err)
);

// File: tb/bus_cycle_timer_tb.sv
module bus_cycle_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       slow_mem;
    logic       req;
    logic [1:0] req_space;
    logic [1:0] req_region;
    logic       req_write;
    logic       rd_n, wr_n, busy, done, code_err;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    bus_cycle_timer u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .slow_mem(slow_mem),
        .req(req), .req_space(req_space), .req_region(req_region),
        .req_write(req_write), .rd_n(rd_n), .wr_n(wr_n), .busy(busy),
        .done(done), .code_err(code_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input string tag, input int a, input int exp);
        @(negedge clk);
        cfg_addr = 2'(a);
        #1;
        check(tag, int'(cfg_rdata), exp);
    endtask

    // n: total cycles; s_lo..s_hi: strobe-low cycles (s_lo 0 means none);
    // noisy: keep req high with other fields during cycles 1..n-1
    task automatic run_access(input string tag, input int space, input int region,
                              input bit wr, input int n, input int s_lo,
                              input int s_hi, input bit noisy);
        @(negedge clk);
        req = 1'b1; req_space = 2'(space); req_region = 2'(region); req_write = wr;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (noisy && k < n) begin
                req = 1'b1; req_region = 2'd1; req_write = ~wr; req_space = 2'(space + 1);
            end else begin
                req = 1'b0;
            end
            begin
                bit strobe;
                strobe = (s_lo != 0) && k >= s_lo && k <= s_hi;
                check({tag, " busy"}, int'(busy), 1);
                check({tag, " done"}, int'(done), int'(k == n));
                check({tag, " rd_n"}, int'(rd_n), int'(!(strobe && !wr)));
                check({tag, " wr_n"}, int'(wr_n), int'(!(strobe && wr)));
            end
        end
        @(negedge clk);
        check({tag, " idle after"}, int'(busy), 0);
        check({tag, " done after"}, int'(done), 0);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) cfg_read("R1 reset byte", a, 8'h03);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(code_err), 0);
        check("R1 rd_n", int'(rd_n), 1);
        check("R1 wr_n", int'(wr_n), 1);
    endtask

    task automatic t_internal;
        slow_mem = 1'b0;
        run_access("R2 imem fast", 0, 0, 1'b0, 1, 0, 0, 1'b0);
        slow_mem = 1'b1;
        run_access("R2 imem slow", 0, 0, 1'b1, 2, 0, 0, 1'b0);
        slow_mem = 1'b0;
    endtask

    task automatic t_sfr;
        run_access("R3 sfr", 1, 1, 1'b0, 2, 0, 0, 1'b0);
        slow_mem = 1'b1;
        run_access("R3 sfr slow", 2, 1, 1'b1, 2, 0, 0, 1'b0);
        slow_mem = 1'b0;
    endtask

    task automatic t_external;
        run_access("R4 R10 default read", 0, 2, 1'b0, 4, 2, 4, 1'b0);
        cfg_write(1, 8'h0A);                       // 2+2
        run_access("R4 R10 2+2 write", 1, 3, 1'b1, 4, 3, 4, 1'b0);
        cfg_write(1, 8'h15);                       // 3+5
        run_access("R4 3+5 read", 1, 2, 1'b0, 8, 4, 8, 1'b0);
        cfg_write(0, 8'h01);                       // 1+1
        run_access("R4 1+1 write", 0, 2, 1'b1, 2, 2, 2, 1'b0);
        cfg_write(0, 8'h03);
    endtask

    task automatic t_recovery;
        cfg_write(3, 8'h56);                       // recov + 3+6
        cfg_read("R5 readback", 3, 8'h56);
        run_access("R5 3+6+rec read", 3, 2, 1'b0, 10, 4, 9, 1'b0);
        cfg_write(3, 8'h41);                       // recov + 1+1
        run_access("R5 1+1+rec write", 3, 2, 1'b1, 3, 2, 2, 1'b0);
    endtask

    task automatic t_independent;
        cfg_read("R11 space0", 0, 8'h03);
        cfg_read("R11 space1", 1, 8'h15);
        cfg_read("R11 space2", 2, 8'h03);
        cfg_read("R11 space3", 3, 8'h41);
        run_access("R11 space2 default", 2, 2, 1'b0, 4, 2, 4, 1'b0);
    endtask

    task automatic t_reserved;
        cfg_write(1, 8'hA5);                       // bits7,5 set, code 1+5
        cfg_read("R8 reserved read", 1, 8'h05);
        run_access("R8 timing 1+5", 1, 2, 1'b0, 6, 2, 6, 1'b0);
        check("R8 no err", int'(code_err), 0);
    endtask

    task automatic t_busy_ignore;
        run_access("R7 noisy ext", 0, 2, 1'b0, 4, 2, 4, 1'b1);
    endtask

    task automatic t_illegal;
        cfg_write(2, 8'h5F);                       // recov + illegal 11111
        #1;
        check("R9 err set", int'(code_err), 1);
        cfg_read("R9 readback", 2, 8'h5F);
        run_access("R9 fallback 1+3+rec", 2, 2, 1'b1, 5, 2, 4, 1'b0);
        cfg_write(2, 8'h03);
        #1;
        check("R9 err sticky", int'(code_err), 1);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        slow_mem = 1'b0; req = 1'b0; req_space = '0; req_region = '0; req_write = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_internal();
        t_sfr();
        t_external();
        t_recovery();
        t_independent();
        t_reserved();
        t_busy_ignore();
        t_illegal();
        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule